// File: doc/BRIEF.md
# Reference Pulse Validity Monitor

This block watches a reference pulse that is meant to be high for exactly one clock cycle and to repeat at a fixed nominal spacing. In the default setup the spacing is one millisecond of a 48 MHz clock. The block measures the number of cycles between consecutive pulses and accepts an interval only when it falls inside a tolerance window. The window is centred on the nominal spacing and its width comes from a parts-per-million figure. From this the block drives a valid flag that tells downstream logic whether the pulse train can be trusted. It also drives a sticky error flag that records that at least one deviation has happened since reset.

After reset, and after any deviation, the monitor is disarmed. The next rising pulse only starts the interval count. The valid flag rises when a later pulse lands inside the window. Three events are deviations: a pulse that comes before the window opens, a window that closes with no pulse, and a pulse held high on two consecutive cycles. Each of them clears the valid flag on the clock edge that samples it and disarms the monitor.

Top module: `refpulse_validity_monitor`

## Requirements
- R1: The accept window runs from NOMINAL_CYCLES−M to NOMINAL_CYCLES+M inclusive, where M = ceil(NOMINAL_CYCLES·TOL_PPM/1,000,000). The interval is the number of clock edges from one sampled pulse cycle to the next.
- R2: While `rst_n` is sampled low, the monitor returns to disarmed and both `ref_valid` and `err_sticky` read 0 after that edge.
- R3: A pulse that arrives while the monitor is disarmed (after reset or after a deviation) only arms it; `ref_valid` stays 0.
- R4: On an armed monitor, a single-cycle pulse whose interval is inside the window sets `ref_valid` to 1 at the edge that samples it.
- R5: A pulse whose interval is below the window's lower bound is a deviation: `ref_valid` is 0 after that edge and the monitor is disarmed. That pulse does not arm it.
- R6: If HI = NOMINAL_CYCLES+M edges pass after the last accepted or arming pulse with no pulse, `ref_valid` is 0 after edge HI and the monitor is disarmed.
- R7: A pulse sampled high on two consecutive edges while armed is a deviation at the second edge. The first edge is judged as a normal pulse.
- R8: `err_sticky` becomes 1 at the edge of any deviation and stays 1 until reset.
- R9: `ref_valid` stays 1 while every pulse lands in the window, including intervals exactly at the lower and upper bounds.
- R10: After a deviation, `ref_valid` stays 0 until one arming pulse and then one in-window pulse have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the reference pulse domain |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | Reference pulse, expected one cycle wide |
| ref_valid | output | 1 | Pulse train trusted |
| err_sticky | output | 1 | A deviation has occurred since reset |

## Verification
Both outputs are registered, so every verdict shows up on the clock edge that samples the pulse cycle or the window-closing cycle that causes it, with no further latency. The bench drives the pulse mid-cycle and advances a behavioural model at the same rising edge as the design. It compares both outputs just after the next falling edge, so each result is checked in the first cycle it is due. The directed checks use the same timing: they count the edges since the last pulse, including boundary intervals of exactly LO and HI and a timeout of exactly HI idle edges.

// File: rtl/rpv_pkg.sv
// Shared types and window arithmetic for the reference pulse validity monitor.
// Assumes TOL_PPM * NOMINAL fits in 64 bits.
package rpv_pkg;

    typedef enum logic {
        MON_IDLE  = 1'b0,
        MON_ARMED = 1'b1
    } mon_state_e;

    // Tolerance margin in whole cycles, rounded away from nominal.
    function automatic int unsigned win_margin(input int unsigned nominal,
                                               input int unsigned ppm);
        longint unsigned prod;
        prod = longint'(nominal) * longint'(ppm);
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

endpackage

// File: rtl/rpv_interval_counter.sv
// Counts clock edges since the last restart. A restart loads 1, so on the edge
// N cycles after a restart edge the count reads N. It saturates at all-ones.
// Assumes restart_i is driven by the monitor's pulse logic.
module rpv_interval_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Load on restart, otherwise step up until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (restart_i) begin
            cnt_o <= CNT_W'(1);
        end else if (cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rpv_window_judge.sv
// Compares the running interval count against the accept window bounds.
// Pure combinational; assumes LO <= HI and both fit in CNT_W bits.
module rpv_window_judge #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LO    = 10,
    parameter int unsigned HI    = 20
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             early_o,
    output logic             closing_o
);

    localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);

    // Early below the lower bound; closing once the upper bound is reached.
    always_comb begin
        early_o   = (cnt_i < LO_C);
        closing_o = (cnt_i >= HI_C);
    end

endmodule

// File: rtl/rpv_valid_fsm.sv
// Arming and judging state machine. It tracks whether the monitor is armed,
// classifies each sampled cycle as accept, arm or deviation, and holds the
// valid and sticky error flags. It assumes early_i and closing_i describe
// the interval count for the current cycle.
module rpv_valid_fsm
    import rpv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_i,
    input  logic       early_i,
    input  logic       closing_i,
    output logic       restart_o,
    output logic       valid_o,
    output logic       err_o,
    output mon_state_e state_o
);

    logic       pulse_q;
    logic       rise;
    logic       armed;
    logic       dev;
    logic       accept;
    mon_state_e state_d;
    logic       valid_d;

    // Classify the current cycle.
    always_comb begin
        armed     = (state_o == MON_ARMED);
        rise      = pulse_i && !pulse_q;
        dev       = armed && ((pulse_i && pulse_q) ||
                              (rise && early_i) ||
                              (!pulse_i && closing_i));
        accept    = armed && rise && !early_i;
        restart_o = (!armed && rise) || accept;
    end

    // Next state and next valid value.
    always_comb begin
        state_d = state_o;
        valid_d = valid_o;
        if (!armed) begin
            valid_d = 1'b0;
            if (rise) begin
                state_d = MON_ARMED;
            end
        end else if (dev) begin
            state_d = MON_IDLE;
            valid_d = 1'b0;
        end else if (accept) begin
            valid_d = 1'b1;
        end
    end

    // State, flag and pulse-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= MON_IDLE;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state_o <= state_d;
            valid_o <= valid_d;
            err_o   <= err_o || dev;
            pulse_q <= pulse_i;
        end
    end

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(pulse_i));

    // R7
    wide_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == MON_ARMED && pulse_i && pulse_q) |=> (!valid_o && err_o));

    // R3
    arm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == MON_IDLE) |=> !valid_o);

endmodule

// File: rtl/refpulse_validity_monitor.sv
// Top of the reference pulse validity monitor. It derives the accept window
// from the nominal interval and the ppm tolerance, counts cycles between
// pulses and drives the valid and sticky error flags. It assumes the pulse is
// synchronous to clk.
module refpulse_validity_monitor
    import rpv_pkg::*;
#(
    parameter int unsigned NOMINAL_CYCLES = 48000,
    parameter int unsigned TOL_PPM        = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    output logic ref_valid,
    output logic err_sticky
);

    localparam int unsigned MARGIN = win_margin(NOMINAL_CYCLES, TOL_PPM);
    localparam int unsigned WIN_LO = (NOMINAL_CYCLES > MARGIN) ? NOMINAL_CYCLES - MARGIN : 1;
    localparam int unsigned WIN_HI = NOMINAL_CYCLES + MARGIN;
    localparam int unsigned CNT_W  = $clog2(WIN_HI + 2);

    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic             early;
    logic             closing;
    mon_state_e       state;

    rpv_interval_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .cnt_o     (cnt)
    );

    rpv_window_judge #(.CNT_W(CNT_W), .LO(WIN_LO), .HI(WIN_HI)) u_judge (
        .cnt_i     (cnt),
        .early_o   (early),
        .closing_o (closing)
    );

    rpv_valid_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (ref_pulse),
        .early_i   (early),
        .closing_i (closing),
        .restart_o (restart),
        .valid_o   (ref_valid),
        .err_o     (err_sticky),
        .state_o   (state)
    );

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MON_ARMED) |-> (cnt <= CNT_W'(WIN_HI)));

    // R6
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MON_ARMED && !ref_pulse && cnt == CNT_W'(WIN_HI)) |=>
            (!ref_valid && state == MON_IDLE));

    // R5
    early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MON_ARMED && ref_pulse && cnt < CNT_W'(WIN_LO)) |=>
            (!ref_valid && state == MON_IDLE));

endmodule

// File: tb/refpulse_validity_monitor_tb.sv
// Bench: behavioural timestamp model compared on every clock, plus directed checks.
module refpulse_validity_monitor_tb;

    localparam int NOM = 1000;
    localparam int PPM = 4500;
    localparam int M   = (NOM * PPM + 999999) / 1000000;
    localparam int LO  = NOM - M;
    localparam int HI  = NOM + M;

    logic clk = 1'b0;
    logic rst_n;
    logic ref_pulse;
    logic ref_valid;
    logic err_sticky;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cyc    = 0;
    int last_t = 0;
    bit m_armed = 0;
    bit m_valid = 0;
    bit m_err   = 0;
    bit m_prev  = 0;

    always #4 clk = ~clk;

    refpulse_validity_monitor #(.NOMINAL_CYCLES(NOM), .TOL_PPM(PPM)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_pulse  (ref_pulse),
        .ref_valid  (ref_valid),
        .err_sticky (err_sticky)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_dev();
        m_armed = 0;
        m_valid = 0;
        m_err   = 1;
    endtask

    // One rising edge of the model, given the sampled pulse value.
    task automatic model_step(input bit p, input bit r);
        int el;
        cyc++;
        if (!r) begin
            m_armed = 0; m_valid = 0; m_err = 0; m_prev = 0;
            return;
        end
        el = cyc - last_t;
        if (!m_armed) begin
            if (p && !m_prev) begin
                m_armed = 1;
                last_t  = cyc;
            end
        end else if (p && m_prev) begin
            model_dev();
        end else if (p) begin
            if (el < LO) model_dev();
            else begin
                m_valid = 1;
                last_t  = cyc;
            end
        end else if (el >= HI) begin
            model_dev();
        end
        m_prev = p;
    endtask

    // Drive one cycle, advance model at the edge, compare after the falling edge.
    task automatic tick(input bit p);
        ref_pulse = p;
        @(posedge clk);
        model_step(p, rst_n);
        @(negedge clk);
        check(ref_valid, m_valid, "R2 R3 R4 R5 R6 R9 R10 model valid");
        check(err_sticky, m_err, "R8 model err");
    endtask

    // Interval of n edges: n-1 idle cycles then a one-cycle pulse.
    task automatic gap(input int n);
        for (int i = 0; i < n - 1; i++) tick(1'b0);
        tick(1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1'b0);
        tick(1'b0);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ref_pulse = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        do_reset();
        // R2 reset state
        check(ref_valid, 1'b0, "R2 valid after reset");
        check(err_sticky, 1'b0, "R2 err after reset");

        // R3 arming pulse only arms
        gap(7);
        check(ref_valid, 1'b0, "R3 arming pulse");
        // R4 nominal interval validates
        gap(NOM);
        check(ref_valid, 1'b1, "R4 in-window pulse");
        // R9 R1 bounds accepted
        gap(LO);
        check(ref_valid, 1'b1, "R9 R1 lower bound");
        gap(HI);
        check(ref_valid, 1'b1, "R9 R1 upper bound");
        gap(NOM);
        check(err_sticky, 1'b0, "R8 no deviation yet");

        // R5 early pulse
        gap(LO - 1);
        check(ref_valid, 1'b0, "R5 early pulse drops valid");
        check(err_sticky, 1'b1, "R8 early sets err");
        // R10 next pulse only arms, the one after validates
        gap(NOM);
        check(ref_valid, 1'b0, "R10 re-arm only");
        gap(NOM);
        check(ref_valid, 1'b1, "R10 revalidated");

        // R6 timeout exactly at HI
        for (int i = 0; i < HI - 1; i++) tick(1'b0);
        check(ref_valid, 1'b1, "R6 still valid before close");
        tick(1'b0);
        check(ref_valid, 1'b0, "R6 timeout drops valid");
        gap(20);
        check(ref_valid, 1'b0, "R3 arm after timeout");
        gap(NOM);
        check(ref_valid, 1'b1, "R10 valid after timeout recovery");

        // R7 wide pulse
        gap(NOM);
        check(ref_valid, 1'b1, "R7 first cycle judged normally");
        tick(1'b1);
        check(ref_valid, 1'b0, "R7 second cycle is deviation");
        tick(1'b1);
        check(ref_valid, 1'b0, "R7 held level does not arm");
        gap(NOM);
        check(ref_valid, 1'b0, "R3 arm after wide pulse");
        gap(NOM);
        check(ref_valid, 1'b1, "R4 valid again");
        check(err_sticky, 1'b1, "R8 err still set");

        // R2 reset clears sticky error
        do_reset();
        check(err_sticky, 1'b0, "R2 err cleared by reset");
        check(ref_valid, 1'b0, "R2 valid cleared by reset");
        gap(3);
        gap(HI + 1);
        check(ref_valid, 1'b0, "R6 R1 beyond upper bound");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule